// File: doc/BRIEF.md
# Flash Command Sequencer

This block fronts a small embedded flash array and turns register writes into erase and program operations. Software talks to it through a 32-bit register port that selects one of five registers: key, control, address, status and wait configuration. A separate write port carries flash data writes, and a separate read port returns array contents. The array is a behavioural memory. Every accepted operation keeps the block busy for a fixed number of cycles and then commits its result in one step.

Nothing can be erased or programmed until two key words have been written in the right order. A bad key locks the block until the next reset. Every request is checked before it starts, for alignment, write protection and whether the target is already erased. A request that fails a check raises a sticky error flag and changes nothing. A request that passes ends with a done flag. All four flags are cleared by writing 1 to them. Two interrupt outputs report done and error, each gated by its own enable bit.

Top module: `flash_seq`

## Requirements
- R1: After reset the status register reads 0, the wait register reads 0, the control register reads 0x10 (bit 4 = locked), and every array word reads 0xFFFFFFFF.
- R2: While locked, control writes cannot set the operation bits (bit 0 program, bit 1 page erase, bit 2 mass erase) and flash data writes leave the array unchanged. Writing KEY_A and then KEY_B to the key register (select 0) unlocks the block.
- R3: Writing 1 to control bit 4 locks the block at any time, and only the full key pair unlocks it again. A key write that does not match the expected word locks the block until reset, even if the correct pair follows.
- R4: Writing control with bit 3 (start) and bit 1 set erases the page that holds the address register to all ones. Busy (status bit 0) stays high for exactly LAT cycles, and bit 3 always reads back 0.
- R5: Start together with bit 2 erases every page to all ones. No address is needed.
- R6: With bit 0 set and the wide bit (wait bit 3) clear, a flash write to an erased, word-aligned location stores the data once busy falls. The done flag (status bit 4) then sets.
- R7: A program request whose target is not all ones sets the program error flag (status bit 1). The array is unchanged and busy never rises.
- R8: With the wide bit set, a write to an 8-byte-aligned address followed by a write to that address + 4 stores both words as one operation. The first write alone changes nothing.
- R9: The alignment flag (status bit 2) is set, and nothing is written, by a word program whose address has nonzero low two bits, by a first wide write that is not 8-byte aligned, or by a second wide write whose address is not the first address + 4.
- R10: An erase or program aimed at a page whose wp_mask bit is 1 sets the protect flag (status bit 3) and does nothing. Mass erase is refused if any mask bit is set.
- R11: Status bits 1 to 4 are cleared by writing 1 to them. Done is set only when busy falls after an operation that was accepted.
- R12: irq_end is high exactly when done and control bit 5 are both set. irq_err is high exactly when any error flag and control bit 6 are both set.
- R13: Status bits 7:5 hold a summary code: 1 while busy, otherwise 2 if the protect flag is set, otherwise 3 if the program error flag is set, otherwise 0.
- R14: The wait register (select 4) holds a wait count in bits 1:0 that accepts only 0, 1 or 2 (a write of 3 keeps the old count), a prefetch bit in bit 2 and the wide bit in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 key, 1 control, 2 address, 3 status, 4 wait |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| fl_we | input | 1 | Flash data write strobe |
| fl_addr | input | AW | Byte address of the flash data write |
| fl_wdata | input | 32 | Flash data write word |
| fl_raddr | input | AW | Byte address for array read |
| fl_rdata | output | 32 | Array word at fl_raddr |
| wp_mask | input | PAGES | Per-page write protect, 1 = protected |
| irq_end | output | 1 | Done interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench covers the key sequence, including a bad first key followed by the correct pair. A design that accepted this pair would unlock, and control writes would then read back the program bit. It programs a word twice, which catches a design that ANDs data into a used location instead of raising the program error. It splits a wide program with a mismatched second address, and leaves a wide program half-issued, to catch designs that commit early or commit on the wrong pair. It also stacks protect and program errors to check the summary priority, and counts busy cycles on a page erase to catch a latency that is off by one.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_WORD, OP_DWORD, OP_PAGE, OP_MASS} op_kind_t;

  localparam logic [2:0] SEL_KEY  = 3'd0;
  localparam logic [2:0] SEL_CTL  = 3'd1;
  localparam logic [2:0] SEL_ADDR = 3'd2;
  localparam logic [2:0] SEL_STAT = 3'd3;
  localparam logic [2:0] SEL_WAIT = 3'd4;

  // a flash location is erased when every bit is one
  function automatic logic is_blank(input logic [31:0] w);
    return &w;
  endfunction

  // status summary: busy over protect error over program error
  function automatic logic [2:0] summary_code(input logic busy, input logic wp, input logic pe);
    if (busy) return 3'd1;
    if (wp)   return 3'd2;
    if (pe)   return 3'd3;
    return 3'd0;
  endfunction
endpackage

// File: rtl/flash_seq_keylock.sv
module flash_seq_keylock #(
  parameter logic [31:0] KEY_A = 32'h5A3C_0F19,
  parameter logic [31:0] KEY_B = 32'hC3A5_96E1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        locked
);
  typedef enum logic [1:0] {K_WAIT_A, K_WAIT_B, K_OPEN, K_DEAD} kst_t;
  kst_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= K_WAIT_A;
    else if (relock && st_q == K_OPEN) st_q <= K_WAIT_A;
    else if (key_we) begin
      case (st_q)
        K_WAIT_A: st_q <= (key_data == KEY_A) ? K_WAIT_B : K_DEAD;
        K_WAIT_B: st_q <= (key_data == KEY_B) ? K_OPEN : K_DEAD;
        default:  st_q <= st_q;
      endcase
    end
  end

  assign locked = (st_q != K_OPEN);
endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
  import flash_seq_pkg::*;
#(
  parameter int WORDS      = 64,
  parameter int PAGE_WORDS = 8,
  localparam int IW  = $clog2(WORDS),
  localparam int PWB = $clog2(PAGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cm_en,
  input  op_kind_t      cm_kind,
  input  logic [IW-1:0] cm_idx,
  input  logic [31:0]   cm_d0,
  input  logic [31:0]   cm_d1,
  input  logic [IW-1:0] ra_idx,
  output logic [31:0]   ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [31:0]   rb_data,
  input  logic [IW-1:0] rx_idx,
  output logic [31:0]   rx_data
);
  logic [31:0] mem_w [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    localparam logic [IW-1:0] ME = IW'(g);
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else if (cm_en) begin
        case (cm_kind)
          OP_WORD:  if (cm_idx == ME) q <= cm_d0;
          OP_DWORD: begin
            if (cm_idx == ME) q <= cm_d0;
            else if ((cm_idx | IW'(1)) == ME) q <= cm_d1;
          end
          OP_PAGE:  if ((cm_idx >> PWB) == (ME >> PWB)) q <= '1;
          default:  q <= '1;
        endcase
      end
    end
    assign mem_w[g] = q;
  end

  assign ra_data = mem_w[ra_idx];
  assign rb_data = mem_w[rb_idx];
  assign rx_data = mem_w[rx_idx];
endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int WORDS      = 64,
  parameter int PAGE_WORDS = 8,
  parameter int LAT        = 4,
  localparam int IW    = $clog2(WORDS),
  localparam int AW    = IW + 2,
  localparam int PAGES = WORDS / PAGE_WORDS,
  localparam int PW    = $clog2(PAGES),
  localparam int PWB   = $clog2(PAGE_WORDS),
  localparam int CW    = $clog2(LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             locked,
  input  logic             prog_en,
  input  logic             wide,
  input  logic             erase_go,
  input  logic             erase_mass,
  input  logic [AW-1:0]    erase_addr,
  input  logic             fl_we,
  input  logic [AW-1:0]    fl_addr,
  input  logic [31:0]      fl_wdata,
  input  logic [PAGES-1:0] wp_mask,
  output logic [IW-1:0]    ra_idx,
  input  logic [31:0]      ra_data,
  output logic [IW-1:0]    rb_idx,
  input  logic [31:0]      rb_data,
  output logic             busy,
  output logic             cm_en,
  output op_kind_t         cm_kind,
  output logic [IW-1:0]    cm_idx,
  output logic [31:0]      cm_d0,
  output logic [31:0]      cm_d1,
  output logic             ev_done,
  output logic             ev_wp,
  output logic             ev_prog,
  output logic             ev_align
);
  function automatic logic [PW-1:0] page_of(input logic [AW-1:0] a);
    return a[AW-1:PWB+2];
  endfunction

  logic          busy_q, half_q;
  logic [CW-1:0] cnt_q;
  op_kind_t      kind_q, l_kind;
  logic [IW-1:0] idx_q, half_idx_q, l_idx, w_idx;
  logic [31:0]   d0_q, d1_q, half_d_q, l_d0, l_d1;
  logic          launch, half_set, half_clr, prog_wr, wp_here;

  assign w_idx   = fl_addr[AW-1:2];
  assign ra_idx  = w_idx;
  assign rb_idx  = half_idx_q;
  assign prog_wr = fl_we && prog_en && !locked && !busy_q;
  assign wp_here = wp_mask[page_of(fl_addr)];

  always_comb begin
    launch = 1'b0; l_kind = OP_WORD; l_idx = w_idx; l_d0 = fl_wdata; l_d1 = fl_wdata;
    ev_wp = 1'b0; ev_prog = 1'b0; ev_align = 1'b0; half_set = 1'b0; half_clr = 1'b0;
    if (erase_go) begin
      if (erase_mass) begin
        if (|wp_mask) ev_wp = 1'b1;
        else begin launch = 1'b1; l_kind = OP_MASS; end
      end else if (wp_mask[page_of(erase_addr)]) ev_wp = 1'b1;
      else begin launch = 1'b1; l_kind = OP_PAGE; l_idx = erase_addr[AW-1:2]; end
    end else if (prog_wr) begin
      if (!wide) begin
        if (fl_addr[1:0] != 2'b00) ev_align = 1'b1;
        else if (wp_here) ev_wp = 1'b1;
        else if (!is_blank(ra_data)) ev_prog = 1'b1;
        else launch = 1'b1;
      end else if (!half_q) begin
        if (fl_addr[2:0] != 3'b000) ev_align = 1'b1;
        else half_set = 1'b1;
      end else begin
        half_clr = 1'b1;
        if (w_idx != half_idx_q + IW'(1)) ev_align = 1'b1;
        else if (wp_here) ev_wp = 1'b1;
        else if (!is_blank(ra_data) || !is_blank(rb_data)) ev_prog = 1'b1;
        else begin
          launch = 1'b1; l_kind = OP_DWORD; l_idx = half_idx_q; l_d0 = half_d_q; l_d1 = fl_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; kind_q <= OP_WORD; idx_q <= '0; d0_q <= '0; d1_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1; cnt_q <= CW'(LAT - 1);
      kind_q <= l_kind; idx_q <= l_idx; d0_q <= l_d0; d1_q <= l_d1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0; half_idx_q <= '0; half_d_q <= '0;
    end else if (locked || !wide) half_q <= 1'b0;
    else if (half_set) begin
      half_q <= 1'b1; half_idx_q <= w_idx; half_d_q <= fl_wdata;
    end else if (half_clr) half_q <= 1'b0;
  end

  assign busy    = busy_q;
  assign cm_en   = busy_q && (cnt_q == '0);
  assign ev_done = cm_en;
  assign cm_kind = kind_q;
  assign cm_idx  = idx_q;
  assign cm_d0   = d0_q;
  assign cm_d1   = d1_q;
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int          WORDS      = 64,
  parameter int          PAGE_WORDS = 8,
  parameter int          LAT        = 4,
  parameter logic [31:0] KEY_A      = 32'h5A3C_0F19,
  parameter logic [31:0] KEY_B      = 32'hC3A5_96E1,
  localparam int IW    = $clog2(WORDS),
  localparam int AW    = IW + 2,
  localparam int PAGES = WORDS / PAGE_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             fl_we,
  input  logic [AW-1:0]    fl_addr,
  input  logic [31:0]      fl_wdata,
  input  logic [AW-1:0]    fl_raddr,
  output logic [31:0]      fl_rdata,
  input  logic [PAGES-1:0] wp_mask,
  output logic             irq_end,
  output logic             irq_err
);
  logic wr_key, wr_ctl, wr_addr, wr_stat, wr_wait, relock, locked, busy;
  logic prog_q, per_q, mer_q, eie_q, rie_q, pf_q, wide_q;
  logic [1:0] ws_q;
  logic [AW-1:0] addr_q;
  logic done_q, perr_q, aerr_q, wperr_q;
  logic erase_go, ev_done, ev_wp, ev_prog, ev_align, cm_en;
  op_kind_t cm_kind;
  logic [IW-1:0] cm_idx, ra_idx, rb_idx;
  logic [31:0] cm_d0, cm_d1, ra_data, rb_data;

  assign wr_key  = reg_we && reg_sel == SEL_KEY;
  assign wr_ctl  = reg_we && reg_sel == SEL_CTL;
  assign wr_addr = reg_we && reg_sel == SEL_ADDR;
  assign wr_stat = reg_we && reg_sel == SEL_STAT;
  assign wr_wait = reg_we && reg_sel == SEL_WAIT;
  assign relock  = wr_ctl && reg_wdata[4];
  assign erase_go = wr_ctl && reg_wdata[3] && (reg_wdata[1] || reg_wdata[2])
                    && !reg_wdata[4] && !locked && !busy;

  flash_seq_keylock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk(clk), .rst_n(rst_n), .key_we(wr_key), .key_data(reg_wdata),
    .relock(relock), .locked(locked));

  flash_seq_engine #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS), .LAT(LAT)) u_eng (
    .clk(clk), .rst_n(rst_n), .locked(locked), .prog_en(prog_q), .wide(wide_q),
    .erase_go(erase_go), .erase_mass(reg_wdata[2]), .erase_addr(addr_q),
    .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .wp_mask(wp_mask),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .busy(busy), .cm_en(cm_en), .cm_kind(cm_kind), .cm_idx(cm_idx),
    .cm_d0(cm_d0), .cm_d1(cm_d1), .ev_done(ev_done), .ev_wp(ev_wp),
    .ev_prog(ev_prog), .ev_align(ev_align));

  flash_seq_array #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS)) u_arr (
    .clk(clk), .rst_n(rst_n), .cm_en(cm_en), .cm_kind(cm_kind), .cm_idx(cm_idx),
    .cm_d0(cm_d0), .cm_d1(cm_d1), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data), .rx_idx(fl_raddr[AW-1:2]), .rx_data(fl_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0; per_q <= 1'b0; mer_q <= 1'b0; eie_q <= 1'b0; rie_q <= 1'b0;
      addr_q <= '0; ws_q <= '0; pf_q <= 1'b0; wide_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        eie_q <= reg_wdata[5];
        rie_q <= reg_wdata[6];
        if (relock || locked) begin
          prog_q <= 1'b0; per_q <= 1'b0; mer_q <= 1'b0;
        end else if (!busy) begin
          prog_q <= reg_wdata[0]; per_q <= reg_wdata[1]; mer_q <= reg_wdata[2];
        end
      end
      if (wr_addr) addr_q <= reg_wdata[AW-1:0];
      if (wr_wait) begin
        if (reg_wdata[1:0] != 2'd3) ws_q <= reg_wdata[1:0];
        pf_q   <= reg_wdata[2];
        wide_q <= reg_wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; perr_q <= 1'b0; aerr_q <= 1'b0; wperr_q <= 1'b0;
    end else begin
      perr_q  <= (perr_q  && !(wr_stat && reg_wdata[1])) || ev_prog;
      aerr_q  <= (aerr_q  && !(wr_stat && reg_wdata[2])) || ev_align;
      wperr_q <= (wperr_q && !(wr_stat && reg_wdata[3])) || ev_wp;
      done_q  <= (done_q  && !(wr_stat && reg_wdata[4])) || ev_done;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTL:  reg_rdata = {25'd0, rie_q, eie_q, locked, 1'b0, mer_q, per_q, prog_q};
      SEL_ADDR: reg_rdata = 32'(addr_q);
      SEL_STAT: reg_rdata = {24'd0, summary_code(busy, wperr_q, perr_q),
                             done_q, wperr_q, aerr_q, perr_q, busy};
      SEL_WAIT: reg_rdata = {28'd0, wide_q, pf_q, ws_q};
      default:  reg_rdata = 32'd0;
    endcase
  end

  assign irq_end = done_q && eie_q;
  assign irq_err = (perr_q || aerr_q || wperr_q) && rie_q;
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker #(
  parameter int LAT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic locked,
  input logic done_q,
  input logic ev_prog,
  input logic ev_wp,
  input logic relock
);
  int run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else run_cnt <= 0;
  end

  assert_locked_no_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!locked));
  assert_relock_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> locked);
  assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < LAT));
  assert_no_op_on_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prog |=> !busy);
  assert_no_op_on_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wp |=> !busy);
  assert_done_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy));
endmodule

bind flash_seq flash_seq_checker #(.LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .locked(locked), .done_q(done_q),
  .ev_prog(ev_prog), .ev_wp(ev_wp), .relock(relock));

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
  localparam logic [31:0] KA = 32'h5A3C_0F19;
  localparam logic [31:0] KB = 32'hC3A5_96E1;
  localparam int LATV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, fl_we = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0, fl_wdata = '0, reg_rdata, fl_rdata;
  logic [7:0] fl_addr = '0, fl_raddr = '0, wp_mask = '0;
  logic irq_end, irq_err;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_seq dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_we(fl_we), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_raddr(fl_raddr), .fl_rdata(fl_rdata), .wp_mask(wp_mask),
    .irq_end(irq_end), .irq_err(irq_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rw(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic fw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); fl_we = 1'b1; fl_addr = a; fl_wdata = d;
    @(negedge clk); fl_we = 1'b0;
  endtask

  task automatic mem(input logic [7:0] a, output logic [31:0] d);
    fl_raddr = a; #1; d = fl_rdata;
  endtask

  task automatic wait_idle(output int cycles);
    logic [31:0] s;
    cycles = 0;
    rd(3'd3, s);
    while (s[0] && cycles < 1000) begin
      cycles++; @(negedge clk); rd(3'd3, s);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd1, v); check("R1 ctl", v, 32'h10);
    rd(3'd3, v); check("R1 stat", v, 32'h0);
    rd(3'd4, v); check("R1 wait", v, 32'h0);
    mem(8'h14, v); check("R1 array", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_locked_unlock;
    logic [31:0] v;
    rw(3'd1, 32'h1); rd(3'd1, v); check("R2 locked ctl", v, 32'h10);
    fw(8'h00, 32'h0); mem(8'h00, v); check("R2 locked flash write", v, 32'hFFFF_FFFF);
    rw(3'd0, KA); rw(3'd0, KB); rd(3'd1, v); check("R2 unlock", v, 32'h0);
  endtask

  task automatic t_wait_reg;
    logic [31:0] v;
    rw(3'd4, 32'h2); rd(3'd4, v); check("R14 ws2", v, 32'h2);
    rw(3'd4, 32'h7); rd(3'd4, v); check("R14 ws3 kept", v, 32'h6);
    rw(3'd4, 32'h0); rd(3'd4, v); check("R14 clear", v, 32'h0);
  endtask

  task automatic t_word_prog;
    logic [31:0] v; int c;
    rw(3'd1, 32'h1);
    fw(8'h10, 32'hA5A5_0001);
    rd(3'd3, v); check("R13 busy code", v, 32'h21);
    wait_idle(c);
    mem(8'h10, v); check("R6 word stored", v, 32'hA5A5_0001);
    rd(3'd3, v); check("R11 done set", v, 32'h10);
    check("R12 end masked", {31'd0, irq_end}, 32'h0);
    rw(3'd3, 32'h10); rd(3'd3, v); check("R11 w1c done", v, 32'h0);
  endtask

  task automatic t_prog_err;
    logic [31:0] v;
    rw(3'd1, 32'h41);
    fw(8'h10, 32'h0000_0000);
    rd(3'd3, v); check("R7 prog err code", v, 32'h62);
    mem(8'h10, v); check("R7 unchanged", v, 32'hA5A5_0001);
    check("R12 err irq", {31'd0, irq_err}, 32'h1);
    rw(3'd3, 32'h02); rd(3'd3, v); check("R11 w1c perr", v, 32'h0);
    check("R12 err irq cleared", {31'd0, irq_err}, 32'h0);
    fw(8'h22, 32'h1234_5678);
    rd(3'd3, v); check("R9 word misaligned", v, 32'h04);
    mem(8'h20, v); check("R9 no write", v, 32'hFFFF_FFFF);
    rw(3'd3, 32'h04);
    rw(3'd1, 32'h1);
  endtask

  task automatic t_dword;
    logic [31:0] v; int c;
    rw(3'd4, 32'h8);
    fw(8'h40, 32'h1111_2222);
    rd(3'd3, v); check("R8 half no busy", v, 32'h0);
    mem(8'h40, v); check("R8 half no write", v, 32'hFFFF_FFFF);
    fw(8'h44, 32'h3333_4444);
    wait_idle(c);
    mem(8'h40, v); check("R8 low word", v, 32'h1111_2222);
    mem(8'h44, v); check("R8 high word", v, 32'h3333_4444);
    rw(3'd3, 32'h10);
    fw(8'h4C, 32'h0);
    rd(3'd3, v); check("R9 wide misaligned", v, 32'h04);
    rw(3'd3, 32'h04);
    fw(8'h50, 32'h5555_5555); fw(8'h58, 32'h6666_6666);
    rd(3'd3, v); check("R9 pair mismatch", v, 32'h04);
    mem(8'h50, v); check("R9 pair no write", v, 32'hFFFF_FFFF);
    rw(3'd3, 32'h04);
    rw(3'd4, 32'h0);
  endtask

  task automatic t_protect;
    logic [31:0] v;
    wp_mask = 8'h08;
    fw(8'h60, 32'h7);
    rd(3'd3, v); check("R10 wp code", v, 32'h48);
    mem(8'h60, v); check("R10 no write", v, 32'hFFFF_FFFF);
    fw(8'h10, 32'h0);
    rd(3'd3, v); check("R13 wp over perr", v, 32'h4A);
    rw(3'd3, 32'h0A);
    rw(3'd1, 32'h0C);
    rd(3'd3, v); check("R10 mass refused", v, 32'h48);
    mem(8'h10, v); check("R10 mass no erase", v, 32'hA5A5_0001);
    rw(3'd3, 32'h08);
    wp_mask = 8'h00;
  endtask

  task automatic t_page_erase;
    logic [31:0] v; int c;
    rw(3'd2, 32'h10);
    rw(3'd1, 32'h0A);
    wait_idle(c);
    check("R4 busy cycles", c, LATV);
    mem(8'h10, v); check("R4 page erased", v, 32'hFFFF_FFFF);
    mem(8'h40, v); check("R4 other page kept", v, 32'h1111_2222);
    rd(3'd1, v); check("R4 start reads 0", v, 32'h02);
    rw(3'd3, 32'h10);
  endtask

  task automatic t_mass;
    logic [31:0] v; int c;
    rw(3'd1, 32'h0C);
    wait_idle(c);
    mem(8'h40, v); check("R5 mass low", v, 32'hFFFF_FFFF);
    mem(8'h44, v); check("R5 mass high", v, 32'hFFFF_FFFF);
    rw(3'd1, 32'h20);
    check("R12 end irq", {31'd0, irq_end}, 32'h1);
    rw(3'd3, 32'h10);
    check("R12 end irq cleared", {31'd0, irq_end}, 32'h0);
  endtask

  task automatic t_relock;
    logic [31:0] v;
    rw(3'd1, 32'h10); rd(3'd1, v); check("R3 relock", v, 32'h10);
    rw(3'd0, KA); rw(3'd0, KB); rd(3'd1, v); check("R3 unlock again", v, 32'h0);
    rw(3'd1, 32'h10);
    rw(3'd0, KB); rw(3'd0, KA); rw(3'd0, KB);
    rw(3'd1, 32'h1); rd(3'd1, v); check("R3 bad key stays locked", v, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_locked_unlock(); t_wait_reg(); t_word_prog(); t_prog_err();
    t_dword(); t_protect(); t_page_erase(); t_mass(); t_relock();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule